// File: doc/BRIEF.md
# Prioritized interrupt request/in-service tracker

This block keeps track of fixed-mode interrupts between their arrival and their completion. Three vector-indexed bit sets hold which vectors are waiting, which are being serviced, and whether each was last requested as level or edge. A request carries a vector number and a level flag. Requests to the sixteen lowest vectors are dropped.

When the core is ready and has interrupts enabled, the block moves the most urgent waiting vector into service and presents it to the core. Urgency grows with the vector number, and the class of a vector is its upper four bits. A waiting vector is dispatched only when nothing is in service, or when its class is above the class of the most urgent vector in service. This second case is how a handler gets preempted. A completion write retires the most urgent vector in service. If that vector was level-triggered, the block pulses a broadcast completion message carrying the vector.

Special-delivery interrupts travel on a separate path. That path passes straight through to the core and never touches the bit sets.

Top module: `irq_tracker`

## Requirements
- R1: After reset, all three bit sets are zero and the dispatch and broadcast outputs are low.
- R2: A request whose vector is below 16 sets no waiting bit and changes no trigger bit.
- R3: An accepted request sets the waiting bit at its vector one cycle later. It also writes that vector's trigger bit: 1 for a level request, 0 for an edge request.
- R4: When a dispatch is allowed, the highest-numbered waiting vector moves from waiting to in service on the next edge. In the same edge, disp_valid pulses for one cycle with that vector on disp_vec.
- R5: A completion write while something is in service clears the highest-numbered in-service bit on the next edge.
- R6: If the retired vector's trigger bit is 1, bcast_valid pulses for one cycle on the next edge with that vector on bcast_vec. If the bit is 0, no pulse is produced.
- R7: A vector can be waiting and in service at the same time. Further requests for a vector that is already waiting merge into its single waiting bit.
- R8: While something is in service, a waiting vector is dispatched only if its class (vector bits 7:4) is strictly greater than the class of the highest in-service vector. No completion write is needed for this.
- R9: No dispatch happens in a cycle where core_ready or core_ie is low.
- R10: A completion write while nothing is in service changes no state and produces no broadcast.
- R11: byp_valid and byp_vec appear unchanged on core_byp_valid and core_byp_vec in the same cycle, and they alter none of the bit sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fixed-mode request strobe |
| req_vec | input | 8 | Request vector |
| req_level | input | 1 | 1 = level request, 0 = edge request |
| core_ready | input | 1 | Core can take the next interrupt |
| core_ie | input | 1 | Core interrupts enabled |
| eoi_wr | input | 1 | Completion write strobe |
| byp_valid | input | 1 | Special-delivery strobe |
| byp_vec | input | 8 | Special-delivery vector |
| core_byp_valid | output | 1 | Special delivery to the core |
| core_byp_vec | output | 8 | Special-delivery vector to the core |
| disp_valid | output | 1 | Dispatch pulse |
| disp_vec | output | 8 | Dispatched vector |
| bcast_valid | output | 1 | Broadcast completion pulse |
| bcast_vec | output | 8 | Vector of the retired level interrupt |
| pend | output | 256 | Waiting bit set |
| insv | output | 256 | In-service bit set |
| tmode | output | 256 | Trigger bit set |

## Verification
Some properties are checked by assertions on every cycle. The reserved vectors never appear as waiting. A dispatched vector is always in service. A dispatch never follows a cycle with interrupts disabled. A preempting dispatch always comes from a strictly higher class. A broadcast always follows a completion write that retired something. The scenarios cover what needs history to show. These include the collapse of repeated requests once a vector is both waiting and in service, the order in which nested handlers are retired, a same-class request that has to wait, and a completion write with nothing in service leaving every output unchanged.

// File: rtl/irq_tracker.sv
module irq_tracker #(
  parameter int VW   = 8,
  parameter int RSV  = 16,
  parameter int CLSB = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VW-1:0]       req_vec,
  input  logic                req_level,
  input  logic                core_ready,
  input  logic                core_ie,
  input  logic                eoi_wr,
  input  logic                byp_valid,
  input  logic [VW-1:0]       byp_vec,
  output logic                core_byp_valid,
  output logic [VW-1:0]       core_byp_vec,
  output logic                disp_valid,
  output logic [VW-1:0]       disp_vec,
  output logic                bcast_valid,
  output logic [VW-1:0]       bcast_vec,
  output logic [(1<<VW)-1:0]  pend,
  output logic [(1<<VW)-1:0]  insv,
  output logic [(1<<VW)-1:0]  tmode
);
  localparam int NVEC = 1 << VW;

  function automatic logic [VW-1:0] top_idx(input logic [NVEC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (v[i]) r = i[VW-1:0];
    return r;
  endfunction

  logic [VW-1:0]   hp_pend, hp_isv;
  logic            pend_any, isv_any, do_disp, do_eoi, do_acc;
  logic [NVEC-1:0] pend_n, insv_n, tmode_n;

  assign core_byp_valid = byp_valid;
  assign core_byp_vec   = byp_vec;

  assign pend_any = |pend;
  assign isv_any  = |insv;
  assign hp_pend  = top_idx(pend);
  assign hp_isv   = top_idx(insv);
  assign do_acc   = req_valid && (req_vec >= VW'(RSV));
  assign do_eoi   = eoi_wr && isv_any;
  assign do_disp  = core_ready && core_ie && pend_any &&
                    (!isv_any || hp_pend[VW-1:CLSB] > hp_isv[VW-1:CLSB]);

  always_comb begin
    pend_n  = pend;
    insv_n  = insv;
    tmode_n = tmode;
    if (do_eoi)  insv_n[hp_isv] = 1'b0;
    if (do_disp) begin
      pend_n[hp_pend] = 1'b0;
      insv_n[hp_pend] = 1'b1;
    end
    if (do_acc) begin
      pend_n[req_vec]  = 1'b1;
      tmode_n[req_vec] = req_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= '0;
      insv        <= '0;
      tmode       <= '0;
      disp_valid  <= 1'b0;
      disp_vec    <= '0;
      bcast_valid <= 1'b0;
      bcast_vec   <= '0;
    end else begin
      pend        <= pend_n;
      insv        <= insv_n;
      tmode       <= tmode_n;
      disp_valid  <= do_disp;
      bcast_valid <= do_eoi && tmode[hp_isv];
      if (do_disp) disp_vec <= hp_pend;
      if (do_eoi)  bcast_vec <= hp_isv;
    end
  end

  a_r2_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pend[RSV-1:0] == '0);
  a_r4_disp_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> insv[disp_vec]);
  a_r9_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(core_ie) && $past(core_ready));
  a_r8_preempt_class: assert property (@(posedge clk) disable iff (!rst_n)
    (do_disp && isv_any) |=> disp_vec[VW-1:CLSB] > $past(hp_isv[VW-1:CLSB]));
  a_r6_bcast_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> $past(eoi_wr) && $past(isv_any));
  a_r10_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !isv_any) |=> !bcast_valid);
endmodule

// File: tb/test_irq_tracker.sv
module test_irq_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_level = 0, core_ready = 0, core_ie = 0, eoi_wr = 0, byp_valid = 0;
  logic [7:0] req_vec = 0, byp_vec = 0;
  logic core_byp_valid, disp_valid, bcast_valid;
  logic [7:0] core_byp_vec, disp_vec, bcast_vec;
  logic [255:0] pend, insv, tmode;

  always #5 clk = ~clk;

  irq_tracker i_irq_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_level(req_level), .core_ready(core_ready), .core_ie(core_ie),
    .eoi_wr(eoi_wr), .byp_valid(byp_valid), .byp_vec(byp_vec),
    .core_byp_valid(core_byp_valid), .core_byp_vec(core_byp_vec),
    .disp_valid(disp_valid), .disp_vec(disp_vec), .bcast_valid(bcast_valid),
    .bcast_vec(bcast_vec), .pend(pend), .insv(insv), .tmode(tmode));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic [255:0] m_pend = '0, m_insv = '0, m_tmode = '0;
  bit m_dv = 0, m_bv = 0;
  int m_dvec = 0, m_bvec = 0;

  always @(posedge clk) begin
    int hp, hi;
    bit go, ret;
    if (!rst_n) begin
      m_pend = '0; m_insv = '0; m_tmode = '0; m_dv = 0; m_bv = 0;
    end else begin
      hp = -1; hi = -1;
      for (int i = 0; i < 256; i++) begin
        if (m_pend[i]) hp = i;
        if (m_insv[i]) hi = i;
      end
      go  = core_ready && core_ie && hp >= 0 && (hi < 0 || (hp / 16) > (hi / 16));
      ret = eoi_wr && hi >= 0;
      m_bv = ret && m_tmode[hi < 0 ? 0 : hi];
      if (ret) m_bvec = hi;
      m_dv = go;
      if (go) m_dvec = hp;
      if (ret) m_insv[hi] = 1'b0;
      if (go) begin m_pend[hp] = 1'b0; m_insv[hp] = 1'b1; end
      if (req_valid && req_vec >= 16) begin
        m_pend[req_vec] = 1'b1;
        m_tmode[req_vec] = req_level;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(pend == m_pend, "R2 R3 R7 waiting set", pend, m_pend);
    chk(insv == m_insv, "R4 R5 R8 in-service set", insv, m_insv);
    chk(tmode == m_tmode, "R3 trigger set", tmode, m_tmode);
    chk(disp_valid == m_dv, "R4 R8 R9 dispatch strobe", 256'(disp_valid), 256'(m_dv));
    if (m_dv) chk(disp_vec == 8'(m_dvec), "R4 R8 dispatch vector", 256'(disp_vec), 256'(m_dvec));
    chk(bcast_valid == m_bv, "R6 R10 broadcast strobe", 256'(bcast_valid), 256'(m_bv));
    if (m_bv) chk(bcast_vec == 8'(m_bvec), "R6 broadcast vector", 256'(bcast_vec), 256'(m_bvec));
  end

  task automatic req(input int v, input bit lvl);
    req_valid = 1; req_vec = 8'(v); req_level = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic eoi();
    eoi_wr = 1;
    @(negedge clk);
    eoi_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(pend == 0 && insv == 0 && tmode == 0 && !disp_valid && !bcast_valid,
        "R1 reset state", pend | insv | tmode, 256'd0);
    req(5, 1);
    idle(1);
    chk(pend == 0 && tmode == 0, "R2 reserved vector dropped", pend, 256'd0);
    core_ready = 1;
    req(8'h30, 0); req(8'h45, 1); req(8'h20, 1);
    idle(2);
    chk(!disp_valid && insv == 0, "R9 held while disabled", insv, 256'd0);
    core_ie = 1;
    idle(2);
    chk(insv[8'h45] && !pend[8'h45], "R4 top vector in service", insv, 256'd1 << 8'h45);
    idle(2);
    chk(insv == (256'd1 << 8'h45), "R8 lower class waits", insv, 256'd1 << 8'h45);
    eoi();
    chk(bcast_valid && bcast_vec == 8'h45, "R6 level broadcast", 256'(bcast_vec), 256'h45);
    idle(2);
    eoi();
    chk(!bcast_valid, "R6 edge no broadcast", 256'(bcast_valid), 256'd0);
    idle(2);
    req(8'h2A, 0);
    idle(2);
    chk(pend[8'h2A] && !insv[8'h2A], "R8 same class waits", pend, 256'd1 << 8'h2A);
    req(8'h90, 0);
    idle(2);
    chk(insv[8'h90] && insv[8'h20], "R8 preemption nests", insv, (256'd1 << 8'h90) | (256'd1 << 8'h20));
    eoi();
    idle(1);
    chk(!insv[8'h90] && insv[8'h20], "R5 top in-service retired", insv, 256'd1 << 8'h20);
    core_ready = 0;
    eoi(); eoi();
    idle(1);
    chk(insv == 0 && pend[8'h2A], "R5 all retired", insv, 256'd0);
    core_ready = 1;
    idle(2);
    eoi();
    core_ready = 0;
    req(8'h50, 1); idle(1);
    core_ready = 1; idle(2); core_ready = 0;
    req(8'h50, 0); req(8'h50, 0); req(8'h50, 1);
    idle(1);
    chk(pend[8'h50] && insv[8'h50], "R7 waiting and in service", pend & insv, 256'd1 << 8'h50);
    eoi(); core_ready = 1; idle(2); core_ready = 0;
    chk(!pend[8'h50] && insv[8'h50], "R7 extra requests merged", pend, 256'd0);
    eoi(); idle(1);
    eoi();
    chk(!bcast_valid && insv == 0, "R10 idle completion ignored", insv, 256'd0);
    byp_valid = 1; byp_vec = 8'h02; #1;
    chk(core_byp_valid && core_byp_vec == 8'h02, "R11 bypass passthrough", 256'(core_byp_vec), 256'h02);
    @(negedge clk); byp_valid = 0;
    idle(1);
    chk(pend == 0 && insv == 0, "R11 bypass leaves sets", pend | insv, 256'd0);
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule